// File: doc/BRIEF.md
# Sync Regeneration Filter

This block sits on the pixel-clock side of a display link receiver. Some transmitters let horizontal sync drift by one clock in either direction from line to line, while data-enable stays fixed to the pixel data. The block rebuilds horizontal and vertical sync from the data-enable timing so that the sync it outputs has a constant position relative to the pixels. Downstream timing controllers then get a steady reference even when the source is not compliant.

For each line the block measures how many clocks separate the data-enable falling edge from the horizontal sync leading edge. After three lines it locks onto the median of those three measurements. From then on it emits a sync pulse at that fixed offset on every line, and it treats a measurement within one clock of the locked value as jitter. A steady move to a new offset causes a relock. It learns the line period from data-enable, which keeps the timing running through vertical blanking lines that carry no data-enable pulse. A compliant source with steady sync passes through unchanged apart from a fixed two-clock latency.

Top module: `sync_regen`

## Requirements
- R1: During and right after synchronous reset, `hsync_out`, `vsync_out` and `locked` are low.
- R2: While `locked` is low, `hsync_out` and `vsync_out` equal `hsync_in` and `vsync_in` delayed by exactly two clocks.
- R3: A line's offset is the number of clocks from the first clock with `de` low after a `de` high clock (offset 0) to the first clock with `hsync_in` high. After three offsets have been measured, `locked` rises and the locked offset is the median of those three values.
- R4: While locked with offset N, `hsync_out` rises in the clock two cycles after the clock at offset N of every line. A stable input at offset N therefore reproduces the input delayed by two clocks. A measured offset of N-1, N or N+1 changes neither the locked offset nor the output.
- R5: A regenerated pulse lasts as many clocks as the most recent input pulse that ended before the regenerated pulse started.
- R6: A single line whose offset differs from N by more than one leaves the output unchanged. A second such line directly after it relocks to the median of the last three offsets. The new offset takes effect in that same line.
- R7: While locked, `vsync_out` changes only in the clock where a regenerated `hsync_out` pulse starts. It takes the `vsync_in` level seen at offset N+1.
- R8: The line period is learned once two consecutive intervals between `de` falling edges are equal. Lines without any `de` pulse then keep the same offset origin, so regeneration continues through vertical blanking.
- R9: Once `locked` has risen it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Incoming horizontal sync, active high, may jitter by one clock |
| vsync_in | input | 1 | Incoming vertical sync, active high |
| de | input | 1 | Data-enable, high during active pixels |
| hsync_out | output | 1 | Regenerated horizontal sync |
| vsync_out | output | 1 | Regenerated vertical sync |
| locked | output | 1 | High once a nominal offset has been acquired |

## Verification
Two events can land in the same clock. An input sync that arrives one clock late falls in the exact clock where the regenerated pulse is launched. That same clock is also the one where `vsync_out` samples its new level and where the pulse width is read. The bench provokes this with late-by-one lines during vertical blanking, and `vsync_in` toggles together with that late sync. It then checks that `vsync_out` switches in the same clock as `hsync_out` rises, and that the pulse keeps the previous line's width. A second overlap happens on the relock line. There the pulse at the old offset has already been launched when the relock decision is taken, so the bench expects two pulses in that line: one at the old offset and one at the new.

// File: rtl/sregen_pkg.sv
package sregen_pkg;

    localparam int OFF_W = 12;

    typedef logic [OFF_W-1:0] off_t;

    localparam off_t OFF_MAX = '1;
    localparam off_t OFF_ONE = off_t'(1);

    typedef enum logic [1:0] {
        LK_ACQ,
        LK_HOLD,
        LK_SUSPECT
    } lock_st_e;

    typedef struct packed {
        logic rise;
        off_t off;
    } hs_evt_t;

    function automatic off_t med3(input off_t a, input off_t b, input off_t c);
        if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
        else if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
        else return c;
    endfunction

    function automatic logic near1(input off_t a, input off_t b);
        off_t d;
        d = (a >= b) ? (a - b) : (b - a);
        return d <= OFF_ONE;
    endfunction

endpackage

// File: rtl/sregen_phase.sv
module sregen_phase
    import sregen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic de,
    output off_t off_now
);
    logic de_q;
    logic fall;
    off_t cnt_r, cnt_d;
    off_t pcnt, pmeas, plen;

    always_comb begin
        fall    = de_q & ~de;
        off_now = fall ? '0 : cnt_r;
        if (off_now == OFF_MAX)
            cnt_d = OFF_MAX;
        else if (plen != '0 && (off_now + OFF_ONE) == plen)
            cnt_d = '0;
        else
            cnt_d = off_now + OFF_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q  <= 1'b0;
            cnt_r <= OFF_MAX;
            pcnt  <= OFF_MAX;
            pmeas <= '0;
            plen  <= '0;
        end else begin
            de_q  <= de;
            cnt_r <= cnt_d;
            if (fall) begin
                pcnt  <= OFF_ONE;
                pmeas <= pcnt;
                if (pcnt == pmeas && pcnt != OFF_MAX && pcnt > OFF_ONE)
                    plen <= pcnt;
            end else if (pcnt != OFF_MAX) begin
                pcnt <= pcnt + OFF_ONE;
            end
        end
    end

    // R8: a learned period restarts the origin exactly one period after the last one
    p_period_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (plen != '0 && !fall && cnt_r == '0) |-> $past(off_now) == plen - OFF_ONE);

endmodule

// File: rtl/sregen_meter.sv
module sregen_meter
    import sregen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hsync_in,
    input  off_t    off_now,
    output hs_evt_t evt,
    output off_t    width
);
    logic hs_q;
    logic rise, fall;
    off_t wcnt;

    always_comb begin
        rise     = ~hs_q & hsync_in;
        fall     = hs_q & ~hsync_in;
        evt.rise = rise;
        evt.off  = off_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b0;
            wcnt  <= '0;
            width <= OFF_ONE;
        end else begin
            hs_q <= hsync_in;
            if (rise)
                wcnt <= OFF_ONE;
            else if (hsync_in && wcnt != OFF_MAX)
                wcnt <= wcnt + OFF_ONE;
            if (fall)
                width <= wcnt;
        end
    end

    // R5: the copied width is never zero
    p_width_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        width != '0);

endmodule

// File: rtl/sregen_lock.sv
module sregen_lock
    import sregen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  hs_evt_t evt,
    output logic    locked,
    output off_t    lock_off
);
    lock_st_e st;
    off_t h0, h1;
    logic [1:0] nval;
    off_t med;
    logic near;

    always_comb begin
        med    = med3(evt.off, h0, h1);
        near   = near1(evt.off, lock_off);
        locked = (st != LK_ACQ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LK_ACQ;
            h0       <= '0;
            h1       <= '0;
            nval     <= '0;
            lock_off <= '0;
        end else if (evt.rise) begin
            h1 <= h0;
            h0 <= evt.off;
            if (nval != 2'd2) nval <= nval + 2'd1;
            case (st)
                LK_ACQ: begin
                    if (nval == 2'd2) begin
                        lock_off <= med;
                        st       <= LK_HOLD;
                    end
                end
                LK_HOLD: begin
                    if (!near) st <= LK_SUSPECT;
                end
                LK_SUSPECT: begin
                    if (!near) lock_off <= med;
                    st <= LK_HOLD;
                end
                default: st <= LK_ACQ;
            endcase
        end
    end

    // R9: lock is sticky
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R4: a measurement within one clock leaves the locked offset alone
    p_jitter_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && evt.rise && near) |=> $stable(lock_off));

    // R6: a first outlier never moves the offset
    p_single_outlier_r6: assert property (@(posedge clk) disable iff (rst)
        (st == LK_HOLD && evt.rise) |=> $stable(lock_off));

endmodule

// File: rtl/sregen_gen.sv
module sregen_gen
    import sregen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic locked,
    input  off_t lock_off,
    input  off_t off_now,
    input  off_t width,
    output logic hsync_out,
    output logic vsync_out
);
    logic hs_d1, vs_d1;
    logic trig;
    off_t rem;

    always_comb begin
        trig = locked && (off_now == lock_off + OFF_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d1     <= 1'b0;
            vs_d1     <= 1'b0;
            hsync_out <= 1'b0;
            vsync_out <= 1'b0;
            rem       <= '0;
        end else begin
            hs_d1 <= hsync_in;
            vs_d1 <= vsync_in;
            if (!locked) begin
                hsync_out <= hs_d1;
                vsync_out <= vs_d1;
                rem       <= '0;
            end else if (trig) begin
                hsync_out <= 1'b1;
                vsync_out <= vsync_in;
                rem       <= width - OFF_ONE;
            end else if (rem != '0) begin
                hsync_out <= 1'b1;
                rem       <= rem - OFF_ONE;
            end else begin
                hsync_out <= 1'b0;
            end
        end
    end

    // R4: when locked, a pulse only starts at the fixed offset
    p_start_at_offset_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && $rose(hsync_out)) |-> $past(trig));

    // R7: vertical sync moves only with a regenerated pulse start
    p_vs_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(locked) && !$stable(vsync_out)) |-> $past(trig));

endmodule

// File: rtl/sync_regen.sv
module sync_regen
    import sregen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic de,
    output logic hsync_out,
    output logic vsync_out,
    output logic locked
);
    off_t    off_now;
    off_t    width;
    off_t    lock_off;
    hs_evt_t evt;

    sregen_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .de      (de),
        .off_now (off_now)
    );

    sregen_meter u_meter (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .off_now  (off_now),
        .evt      (evt),
        .width    (width)
    );

    sregen_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .locked   (locked),
        .lock_off (lock_off)
    );

    sregen_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .locked    (locked),
        .lock_off  (lock_off),
        .off_now   (off_now),
        .width     (width),
        .hsync_out (hsync_out),
        .vsync_out (vsync_out)
    );

    // R1: nothing is driven high in the first clock after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!hsync_out && !vsync_out && !locked));

endmodule

// File: tb/sim_sync_regen.sv
module sim_sync_regen;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic de = 1'b0;
    logic hsync_out, vsync_out, locked;

    localparam int LINE  = 40;
    localparam int BLANK = 20;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    bit  vs_prev = 1'b0;

    always #10 clk = ~clk;

    sync_regen u0 (
        .clk       (clk),
        .rst       (rst),
        .hsync_in  (hsync_in),
        .vsync_in  (vsync_in),
        .de        (de),
        .hsync_out (hsync_out),
        .vsync_out (vsync_out),
        .locked    (locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One line: blanking first (offset 0 = first de-low clock), active part after.
    // Expected pulses seen at sample index i in [off+2, off+1+w].
    task automatic drive_line(input int off_in, input int w_in, input bit act,
                              input bit vs_new, input int exp_off, input int exp_off2,
                              input int exp_w, input bit exp_lock, input string tag);
        int hs_i = -1, hs_a = 0, hs_e = 0;
        int vs_i = -1, vs_a = 0, vs_e = 0;
        bit lk = 1'b0;
        for (int i = 0; i < LINE; i++) begin
            @(negedge clk);
            begin
                bit eh, ev;
                eh = (i >= exp_off + 2 && i < exp_off + 2 + exp_w) ||
                     (exp_off2 >= 0 && i >= exp_off2 + 2 && i < exp_off2 + 2 + exp_w);
                ev = (i >= exp_off + 2) ? vs_new : vs_prev;
                if (hsync_out !== eh && hs_i < 0) begin
                    hs_i = i; hs_a = int'(hsync_out); hs_e = int'(eh);
                end
                if (vsync_out !== ev && vs_i < 0) begin
                    vs_i = i; vs_a = int'(vsync_out); vs_e = int'(ev);
                end
                lk = locked;
            end
            de       = act && (i >= BLANK);
            hsync_in = (i >= off_in && i < off_in + w_in);
            vsync_in = (i >= off_in) ? vs_new : vs_prev;
        end
        chk(hs_i < 0, $sformatf("%s hsync at line cycle %0d", tag, hs_i), hs_a, hs_e);
        chk(vs_i < 0, $sformatf("%s vsync at line cycle %0d", tag, vs_i), vs_a, vs_e);
        chk(lk == exp_lock, $sformatf("%s locked", tag), int'(lk), int'(exp_lock));
        vs_prev = vs_new;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(hsync_out == 1'b0, "R1 hsync_out in reset", int'(hsync_out), 0);
        chk(vsync_out == 1'b0, "R1 vsync_out in reset", int'(vsync_out), 0);
        chk(locked == 1'b0, "R1 locked in reset", int'(locked), 0);
        rst = 1'b0;
        de  = 1'b1;
        repeat (BLANK) @(negedge clk);
    endtask

    // R2 mirror before lock, R3 median of 11,10,6 is 10
    task automatic t_acquire;
        drive_line(11, 4, 1'b1, 1'b0, 11, -1, 4, 1'b0, "R2 mirror line1");
        drive_line(10, 4, 1'b1, 1'b1, 10, -1, 4, 1'b0, "R2 mirror line2 vsync");
        drive_line(6,  4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R3 lock to median");
    endtask

    // R4 jitter of one clock either way is absorbed
    task automatic t_jitter;
        drive_line(9,  4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R4 early by one");
        drive_line(11, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R4 late by one");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R4 stable transparent");
        drive_line(9,  4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R4 early again");
    endtask

    // R5 width follows the last finished input pulse
    task automatic t_width;
        drive_line(10, 6, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R5 width still old");
        drive_line(10, 6, 1'b1, 1'b0, 10, -1, 6, 1'b1, "R5 width widened");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 6, 1'b1, "R5 width lags");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R5 width narrowed");
    endtask

    // R7, R8: blanking lines without de, late/early sync carrying vsync edges
    task automatic t_vblank;
        drive_line(11, 4, 1'b0, 1'b1, 10, -1, 4, 1'b1, "R7 vsync rise late sync");
        drive_line(9,  4, 1'b0, 1'b1, 10, -1, 4, 1'b1, "R8 flywheel line");
        drive_line(9,  4, 1'b0, 1'b0, 10, -1, 4, 1'b1, "R7 vsync fall early sync");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R8 back to active");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R8 active steady");
    endtask

    // R6 single outlier ignored, two in a row relock; R9 lock stays
    task automatic t_relock;
        drive_line(16, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R6 single outlier");
        drive_line(10, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R6 back in window");
        drive_line(16, 4, 1'b1, 1'b0, 10, -1, 4, 1'b1, "R6 first of pair");
        drive_line(16, 4, 1'b1, 1'b0, 10, 16, 4, 1'b1, "R6 relock line");
        drive_line(16, 4, 1'b1, 1'b0, 16, -1, 4, 1'b1, "R9 new offset held");
        drive_line(15, 4, 1'b1, 1'b0, 16, -1, 4, 1'b1, "R4 jitter at new offset");
    endtask

    initial begin
        t_reset;
        t_acquire;
        t_jitter;
        t_width;
        t_vblank;
        t_relock;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule